// File: doc/BRIEF.md
# Prescaled Time-Constant Baud Generator

This block derives serial bit-rate enables from a single base clock. Each of its two sides, receive and transmit, owns an 8-bit time-constant divider followed by a power-of-two prescaler. The strobe period of a side is the time constant multiplied by two raised to the prescale exponent. A stored time constant of zero stands for 256, and the exponent runs from 0 to 9. Each side produces a one-cycle enable pulse at the end of every period. Downstream shift logic uses that pulse as its bit-clock enable.

Software loads the time constant and the exponent of each side through separate write strobes. A new setting is held pending and only becomes active when the current period ends. A period in progress is therefore never cut short or stretched. A loopback control makes the receive strobe follow the transmit timing. The receive divider keeps counting while loopback is on, so it stays in phase when loopback is turned off. The register interface is plain write-enable and data. There is no data stream, so no valid/ready handshake applies.

Top module: `baud_rate_gen`

## Requirements
- R1: While reset is held, both strobes are low. With the reset defaults (time constant 0, exponent 0), the first strobe of each side is high 255 clock edges after the edge-aligned release of reset, and every later strobe comes 256 cycles after the one before.
- R2: With time constant T (1 to 255) and exponent B (0 to 9), a side strobes once every T × 2^B clock cycles.
- R3: A time constant of 0 divides by 256.
- R4: An exponent written with a value above 9 acts as 9, which gives a prescale factor of 512.
- R5: With time constant 1 and exponent 0, the strobe is high on every cycle, so the base rate passes through unchanged.
- R6: When the period is longer than one cycle, each strobe is high for exactly one clock cycle.
- R7: A write that lands in the middle of a period does not change that period. The new value takes effect from the next period on.
- R8: A write that is captured on the same clock edge that ends a period takes effect for the period that begins at that edge.
- R9: The receive and transmit sides use their own settings and count independently of each other.
- R10: While loopback is on, the receive strobe equals the transmit strobe on every cycle. When loopback is turned off, the receive strobe returns to its own setting without being restarted.
- R11: The time constant and the exponent have separate write strobes. Writing one of them leaves the other unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_tc_we | input | 1 | Write strobe for the receive time constant |
| rx_tc | input | TC_W | Receive time constant (0 means 256) |
| rx_ps_we | input | 1 | Write strobe for the receive prescale exponent |
| rx_ps | input | EXP_W | Receive prescale exponent (values above EXP_MAX are clamped) |
| tx_tc_we | input | 1 | Write strobe for the transmit time constant |
| tx_tc | input | TC_W | Transmit time constant (0 means 256) |
| tx_ps_we | input | 1 | Write strobe for the transmit prescale exponent |
| tx_ps | input | EXP_W | Transmit prescale exponent |
| loop_en | input | 1 | Loopback: the receive strobe follows the transmit timing |
| rx_tick | output | 1 | One-cycle receive bit-rate enable |
| tx_tick | output | 1 | One-cycle transmit bit-rate enable |

## Verification
Two things can happen in the same cycle: a configuration write and the terminal count that reloads the counters. The bench provokes this by driving a time-constant write at the very negative edge where it first sees a strobe high. The write is then captured on the edge that ends the period. The bench expects the interval to the following strobe to equal the new period, not the old one. A separate case writes well inside a long period and expects that period to finish at its old length.

// File: rtl/baud_pkg.sv
package baud_pkg;

  typedef enum logic {
    SIDE_RX = 1'b0,
    SIDE_TX = 1'b1
  } side_e;

  localparam int NUM_SIDES = 2;

  // Limit an exponent to the supported maximum.
  function automatic int unsigned exp_limit(input int unsigned e,
                                            input int unsigned lim);
    return (e > lim) ? lim : e;
  endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import baud_pkg::*;
#(
  parameter int TC_W      = 8,
  parameter int EXP_MAX   = 9,
  parameter int EXP_W     = 4,
  parameter int RESET_TC  = 0,
  parameter int RESET_EXP = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tc_we,
  input  logic [TC_W-1:0]  tc_wd,
  input  logic             ps_we,
  input  logic [EXP_W-1:0] ps_wd,
  input  logic             boundary,
  output logic [TC_W-1:0]  act_tc,
  output logic [EXP_W-1:0] act_exp,
  output logic [TC_W-1:0]  nxt_tc,
  output logic [EXP_W-1:0] nxt_exp
);

  logic [TC_W-1:0]  pend_tc;
  logic [EXP_W-1:0] pend_exp;
  logic [EXP_W-1:0] ps_lim;

  assign ps_lim = EXP_W'(exp_limit(32'(ps_wd), EXP_MAX));

  // A write in the boundary cycle bypasses the pending copy.
  always_comb begin
    nxt_tc  = tc_we ? tc_wd  : pend_tc;
    nxt_exp = ps_we ? ps_lim : pend_exp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_tc  <= TC_W'(RESET_TC);
      pend_exp <= EXP_W'(RESET_EXP);
    end else begin
      if (tc_we) pend_tc  <= tc_wd;
      if (ps_we) pend_exp <= ps_lim;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_tc  <= TC_W'(RESET_TC);
      act_exp <= EXP_W'(RESET_EXP);
    end else if (boundary) begin
      act_tc  <= nxt_tc;
      act_exp <= nxt_exp;
    end
  end

endmodule

// File: rtl/baud_div_chain.sv
module baud_div_chain #(
  parameter int TC_W      = 8,
  parameter int EXP_MAX   = 9,
  parameter int EXP_W     = 4,
  parameter int RESET_TC  = 0,
  parameter int RESET_EXP = 0,
  localparam int PS_W     = (EXP_MAX > 0) ? EXP_MAX : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TC_W-1:0]  act_tc,
  input  logic [TC_W-1:0]  nxt_tc,
  input  logic [EXP_W-1:0] nxt_exp,
  output logic             strobe,
  output logic [PS_W-1:0]  ps_cnt
);

  logic [TC_W-1:0] tc_cnt;
  logic            tc_term;
  logic            ps_term;

  function automatic logic [PS_W-1:0] ps_span(input logic [EXP_W-1:0] e);
    return PS_W'((32'd1 << e) - 32'd1);
  endfunction

  // Load value T-1; a stored 0 wraps to 255, i.e. divide by 256.
  function automatic logic [TC_W-1:0] tc_span(input logic [TC_W-1:0] t);
    return TC_W'(t - 1'b1);
  endfunction

  assign tc_term = (tc_cnt == '0);
  assign ps_term = (ps_cnt == '0);
  assign strobe  = tc_term && ps_term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_cnt <= tc_span(TC_W'(RESET_TC));
      ps_cnt <= ps_span(EXP_W'(RESET_EXP));
    end else if (strobe) begin
      tc_cnt <= tc_span(nxt_tc);
      ps_cnt <= ps_span(nxt_exp);
    end else if (tc_term) begin
      tc_cnt <= tc_span(act_tc);
      ps_cnt <= ps_cnt - 1'b1;
    end else begin
      tc_cnt <= tc_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baud_pkg::*;
#(
  parameter int TC_W      = 8,
  parameter int EXP_MAX   = 9,
  parameter int EXP_W     = 4,
  parameter int RESET_TC  = 0,
  parameter int RESET_EXP = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_tc_we,
  input  logic [TC_W-1:0]  rx_tc,
  input  logic             rx_ps_we,
  input  logic [EXP_W-1:0] rx_ps,
  input  logic             tx_tc_we,
  input  logic [TC_W-1:0]  tx_tc,
  input  logic             tx_ps_we,
  input  logic [EXP_W-1:0] tx_ps,
  input  logic             loop_en,
  output logic             rx_tick,
  output logic             tx_tick
);

  localparam int PS_W = (EXP_MAX > 0) ? EXP_MAX : 1;

  logic [NUM_SIDES-1:0]            side_tc_we;
  logic [NUM_SIDES-1:0]            side_ps_we;
  logic [NUM_SIDES-1:0][TC_W-1:0]  side_tc_wd;
  logic [NUM_SIDES-1:0][EXP_W-1:0] side_ps_wd;
  logic [NUM_SIDES-1:0][TC_W-1:0]  side_act_tc;
  logic [NUM_SIDES-1:0][EXP_W-1:0] side_act_exp;
  logic [NUM_SIDES-1:0][TC_W-1:0]  side_nxt_tc;
  logic [NUM_SIDES-1:0][EXP_W-1:0] side_nxt_exp;
  logic [NUM_SIDES-1:0][PS_W-1:0]  side_ps_cnt;
  logic [NUM_SIDES-1:0]            side_strobe;

  assign side_tc_we[SIDE_RX] = rx_tc_we;
  assign side_tc_wd[SIDE_RX] = rx_tc;
  assign side_ps_we[SIDE_RX] = rx_ps_we;
  assign side_ps_wd[SIDE_RX] = rx_ps;
  assign side_tc_we[SIDE_TX] = tx_tc_we;
  assign side_tc_wd[SIDE_TX] = tx_tc;
  assign side_ps_we[SIDE_TX] = tx_ps_we;
  assign side_ps_wd[SIDE_TX] = tx_ps;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    baud_cfg_reg #(
      .TC_W(TC_W), .EXP_MAX(EXP_MAX), .EXP_W(EXP_W),
      .RESET_TC(RESET_TC), .RESET_EXP(RESET_EXP)
    ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .tc_we    (side_tc_we[s]),
      .tc_wd    (side_tc_wd[s]),
      .ps_we    (side_ps_we[s]),
      .ps_wd    (side_ps_wd[s]),
      .boundary (side_strobe[s]),
      .act_tc   (side_act_tc[s]),
      .act_exp  (side_act_exp[s]),
      .nxt_tc   (side_nxt_tc[s]),
      .nxt_exp  (side_nxt_exp[s])
    );

    baud_div_chain #(
      .TC_W(TC_W), .EXP_MAX(EXP_MAX), .EXP_W(EXP_W),
      .RESET_TC(RESET_TC), .RESET_EXP(RESET_EXP)
    ) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_tc  (side_act_tc[s]),
      .nxt_tc  (side_nxt_tc[s]),
      .nxt_exp (side_nxt_exp[s]),
      .strobe  (side_strobe[s]),
      .ps_cnt  (side_ps_cnt[s])
    );
  end

  // Loopback steers transmit timing onto the receive strobe.
  assign tx_tick = side_strobe[SIDE_TX];
  assign rx_tick = loop_en ? side_strobe[SIDE_TX] : side_strobe[SIDE_RX];

endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk #(
  parameter int TC_W    = 8,
  parameter int EXP_MAX = 9,
  parameter int EXP_W   = 4,
  parameter int PS_W    = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  loop_en,
  input logic                  rx_tick,
  input logic                  tx_tick,
  input logic [1:0]            strobe,
  input logic [1:0][TC_W-1:0]  act_tc,
  input logic [1:0][EXP_W-1:0] act_exp,
  input logic [1:0][PS_W-1:0]  ps_cnt
);

  function automatic logic [PS_W-1:0] span(input logic [EXP_W-1:0] e);
    return PS_W'((32'd1 << e) - 32'd1);
  endfunction

  for (genvar s = 0; s < 2; s++) begin : g_chk
    // R4
    exp_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_exp[s] <= EXP_W'(EXP_MAX));

    // R2
    prescale_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ps_cnt[s] <= span(act_exp[s]));

    // R7
    hold_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe[s] |=> ($stable(act_tc[s]) && $stable(act_exp[s])));

    // R6
    single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe[s] |=> (!strobe[s] || (act_tc[s] == TC_W'(1) && act_exp[s] == '0)));
  end

  // R10
  loop_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (rx_tick == tx_tick));

endmodule

bind baud_rate_gen baud_rate_gen_chk #(
  .TC_W(TC_W), .EXP_MAX(EXP_MAX), .EXP_W(EXP_W), .PS_W(PS_W)
) u_baud_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .loop_en (loop_en),
  .rx_tick (rx_tick),
  .tx_tick (tx_tick),
  .strobe  (side_strobe),
  .act_tc  (side_act_tc),
  .act_exp (side_act_exp),
  .ps_cnt  (side_ps_cnt)
);

// File: tb/test_baud_rate_gen.sv
module test_baud_rate_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_tc_we, rx_ps_we, tx_tc_we, tx_ps_we, loop_en;
  logic [7:0] rx_tc, tx_tc;
  logic [3:0] rx_ps, tx_ps;
  logic       rx_tick, tx_tick;

  int cyc = 0;
  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  baud_rate_gen i_baud_rate_gen (
    .clk(clk), .rst_n(rst_n),
    .rx_tc_we(rx_tc_we), .rx_tc(rx_tc), .rx_ps_we(rx_ps_we), .rx_ps(rx_ps),
    .tx_tc_we(tx_tc_we), .tx_tc(tx_tc), .tx_ps_we(tx_ps_we), .tx_ps(tx_ps),
    .loop_en(loop_en), .rx_tick(rx_tick), .tx_tick(tx_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period(input int tc, input int ex);
    int t = (tc == 0) ? 256 : tc;
    int e = (ex > 9) ? 9 : ex;
    return t << e;
  endfunction

  function automatic logic tick_of(input int s);
    return (s == 0) ? rx_tick : tx_tick;
  endfunction

  task automatic wr_tc(input int s, input int v);
    @(negedge clk);
    if (s == 0) begin rx_tc_we = 1; rx_tc = 8'(v); end
    else begin tx_tc_we = 1; tx_tc = 8'(v); end
    @(negedge clk);
    rx_tc_we = 0; tx_tc_we = 0;
  endtask

  task automatic wr_ps(input int s, input int v);
    @(negedge clk);
    if (s == 0) begin rx_ps_we = 1; rx_ps = 4'(v); end
    else begin tx_ps_we = 1; tx_ps = 4'(v); end
    @(negedge clk);
    rx_ps_we = 0; tx_ps_we = 0;
  endtask

  task automatic wait_tick(input int s, output int at);
    do @(negedge clk); while (!tick_of(s));
    at = cyc;
  endtask

  task automatic meas(input int s, output int iv);
    int a, b;
    wait_tick(s, a);
    wait_tick(s, b);
    iv = b - a;
  endtask

  task automatic setup(input int s, input int tc, input int ex);
    int a;
    wr_tc(s, tc);
    wr_ps(s, ex);
    wait_tick(s, a);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 190000);
    errs++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<190000", cyc);
    finish_run();
  end

  initial begin
    int a, b, iv, c0, mism;
    int rtc[2], rex[2];
    rst_n = 0; loop_en = 0;
    rx_tc_we = 0; rx_ps_we = 0; tx_tc_we = 0; tx_ps_we = 0;
    rx_tc = 0; tx_tc = 0; rx_ps = 0; tx_ps = 0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: strobes low during reset
    chk(!rx_tick && !tx_tick, "R1 reset low", {rx_tick, tx_tick}, 0);
    rst_n = 1;
    c0 = cyc;
    wait_tick(0, a);
    chk(a - c0 == 255, "R1 first rx strobe", a - c0, 255);
    chk(tx_tick == 1'b1, "R1 first tx strobe aligned", tx_tick, 1);
    wait_tick(1, b);
    chk(b - a == 256, "R1 reset period", b - a, 256);

    // R2 R9: random settings per side
    for (int it = 0; it < 6; it++) begin
      for (int s = 0; s < 2; s++) begin
        rtc[s] = $urandom_range(1, 40);
        rex[s] = $urandom_range(0, 3);
        setup(s, rtc[s], rex[s]);
      end
      for (int s = 0; s < 2; s++) begin
        meas(s, iv);
        chk(iv == period(rtc[s], rex[s]), "R2 R9 random period", iv, period(rtc[s], rex[s]));
      end
    end

    // R3: zero time constant
    setup(1, 0, 0);
    meas(1, iv);
    chk(iv == 256, "R3 tc zero", iv, 256);

    // R4: exponent clamp
    setup(0, 1, 13);
    meas(0, iv);
    chk(iv == 512, "R4 exp clamp", iv, 512);
    setup(0, 1, 9);
    meas(0, iv);
    chk(iv == 512, "R4 exp max", iv, 512);

    // R5: pass-through
    setup(1, 1, 0);
    mism = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!tx_tick) mism++;
    end
    chk(mism == 0, "R5 pass-through", mism, 0);

    // R6 R11: 3 x 4, then exponent only
    setup(1, 3, 2);
    meas(1, iv);
    chk(iv == 12, "R2 tc3 exp2", iv, 12);
    wait_tick(1, a);
    @(negedge clk);
    chk(tx_tick == 1'b0, "R6 one-cycle strobe", tx_tick, 0);
    wr_ps(1, 0);
    wait_tick(1, a);
    meas(1, iv);
    chk(iv == 3, "R11 exp-only write keeps tc", iv, 3);

    // R7: mid-period write
    setup(1, 100, 0);
    wait_tick(1, a);
    repeat (10) @(negedge clk);
    wr_tc(1, 3);
    wait_tick(1, b);
    chk(b - a == 100, "R7 period not shortened", b - a, 100);
    meas(1, iv);
    chk(iv == 3, "R7 new period applied", iv, 3);

    // R8: write captured on the terminal edge
    setup(1, 10, 0);
    wait_tick(1, a);
    tx_tc_we = 1; tx_tc = 8'd4;
    @(negedge clk);
    tx_tc_we = 0;
    wait_tick(1, b);
    chk(b - a == 4, "R8 same-edge write", b - a, 4);
    meas(1, iv);
    chk(iv == 4, "R8 stays new", iv, 4);

    // R10: loopback
    setup(0, 5, 0);
    setup(1, 7, 0);
    @(negedge clk);
    loop_en = 1;
    meas(0, iv);
    chk(iv == 7, "R10 loop rx follows tx", iv, 7);
    mism = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (rx_tick != tx_tick) mism++;
    end
    chk(mism == 0, "R10 loop equality", mism, 0);
    loop_en = 0;
    meas(0, iv);
    chk(iv == 5, "R10 loop off restores", iv, 5);
    meas(1, iv);
    chk(iv == 7, "R9 tx unaffected", iv, 7);

    finish_run();
  end

endmodule